// File: doc/BRIEF.md
# External Bus Hand-Over Arbiter

This block decides who drives a shared external bus: the local processor, which owns it by default, or an external host. The host asks for the bus on an active-low request line. Before the host is told it may proceed, the arbiter first stops driving the address, data, select and strobe lines. It then leaves the grant line undriven for one clock, and only after that drives the grant low. The grant stays low for as long as the host keeps its request asserted. The host request outranks any bus request raised by the processor itself.

A separate active-low suspend input takes the bus off the wires on the following cycle, whatever the ownership state. An external access that the processor attempts while suspend is active is stalled until suspend has cleared. An access the processor already has in flight is allowed to finish before the bus is handed over.

Every pin is modelled as a value plus an output enable. An output enable of 0 means high impedance.

Top module: `hbus_arbiter`

## Requirements
- R1: After reset the processor owns the bus. The grant is driven high (grant_oe=1, grant_n=1), all four bus enables are 1, core_stall is 0 and core_req_ack is 0 while no processor request is raised.
- R2: When host_req_n is sampled low with core_xfer_active=0 while the processor owns the bus, on the next cycle addr_oe, data_oe, sel_oe, strobe_oe and grant_oe are all 0.
- R3: The undriven-grant period lasts exactly one cycle. If host_req_n is still low, the following cycle has grant_oe=1 and grant_n=0.
- R4: Once driven low, the grant stays low and the bus enables stay 0 for every cycle in which host_req_n is sampled low.
- R5: When host_req_n is sampled high while the grant is driven low, on the next cycle grant_n=1 with grant_oe=1, and the bus enables return to 1 unless suspend is in effect.
- R6: While core_xfer_active=1 the processor keeps the bus even if host_req_n is low. Hand-over starts one cycle after core_xfer_active is sampled 0.
- R7: core_req_ack equals the OR of core_bus_req only while the processor owns the bus and host_req_n is high. Otherwise it is 0, so the host request outranks every processor request.
- R8: suspend_n sampled low forces all four bus enables to 0 on the next cycle. suspend_n sampled high lets them return on the next cycle if the processor owns the bus.
- R9: core_stall is 1 when core_xfer_req=1 and any of the following holds: suspend_n is low now, suspend was sampled low at the last edge, or the host holds or is taking the bus. Otherwise core_stall is 0.
- R10: If host_req_n is sampled high during the undriven-grant cycle, the next cycle returns the bus to the processor (grant_oe=1, grant_n=1, enables 1) without the grant ever going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_n | input | 1 | Host bus request, active low |
| suspend_n | input | 1 | Suspend-and-float request, active low |
| core_xfer_req | input | 1 | Processor wants to start an external access |
| core_xfer_active | input | 1 | Processor external access in progress |
| core_bus_req | input | N_REQ | Processor-side bus requests |
| core_req_ack | output | 1 | A processor bus request is honoured |
| grant_n | output | 1 | Host grant value, active low |
| grant_oe | output | 1 | Host grant output enable |
| addr_oe | output | 1 | Address line drive enable |
| data_oe | output | 1 | Data line drive enable |
| sel_oe | output | 1 | Select line drive enable |
| strobe_oe | output | 1 | Strobe line drive enable |
| core_stall | output | 1 | Halt the processor's external access |

## Verification
Every cycle, the assertions check the following relations:
- the step from a sampled host request to the undriven grant;
- the single-cycle float followed by a driven-low grant;
- grant hold while the request stays low, and grant release when it goes high;
- the float abort;
- suspend taking effect on the next cycle;
- the same-cycle stall and the zero acknowledge while the host is requesting.

Only the bench's scenarios show the whole sequences. These include the deferral behind an in-flight access, a host request arriving while suspend is active, the bus coming back only once suspend clears, and a reset in the middle of a grant.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    OWN_CORE = 2'd0,
    HAND_OFF = 2'd1,
    HOST_HAS = 2'd2
  } own_t;

  function automatic own_t fn_next(own_t cur, logic hreq_n, logic xact);
    own_t nx;
    nx = cur;
    case (cur)
      OWN_CORE: if (!hreq_n && !xact) nx = HAND_OFF;
      HAND_OFF: nx = hreq_n ? OWN_CORE : HOST_HAS;
      HOST_HAS: if (hreq_n) nx = OWN_CORE;
      default:  nx = OWN_CORE;
    endcase
    return nx;
  endfunction

  function automatic logic fn_bus_on(own_t cur, logic susp_seen);
    return (cur == OWN_CORE) && !susp_seen;
  endfunction

  function automatic logic fn_stall(logic xreq, logic susp_n, logic susp_seen, own_t cur);
    return xreq && (!susp_n || susp_seen || (cur != OWN_CORE));
  endfunction

endpackage

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req_n,
  input  logic core_xfer_active,
  output own_t state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OWN_CORE;
    else        state <= fn_next(state, host_req_n, core_xfer_active);
  end
endmodule

// File: rtl/hbus_susp.sv
module hbus_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_n,
  output logic susp_seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_seen <= 1'b0;
    else        susp_seen <= !suspend_n;
  end
endmodule

// File: rtl/hbus_drive.sv
module hbus_drive
  import hbus_pkg::*;
#(
  parameter int N_LINES = 4
) (
  input  own_t               state,
  input  logic               susp_seen,
  output logic [N_LINES-1:0] line_oe,
  output logic               grant_n,
  output logic               grant_oe
);
  logic bus_on;
  assign bus_on = fn_bus_on(state, susp_seen);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_oe[i] = bus_on;
  end

  assign grant_oe = (state != HAND_OFF);
  assign grant_n  = (state != HOST_HAS);
endmodule

// File: rtl/hbus_arbiter.sv
module hbus_arbiter
  import hbus_pkg::*;
#(
  parameter int N_REQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req_n,
  input  logic             suspend_n,
  input  logic             core_xfer_req,
  input  logic             core_xfer_active,
  input  logic [N_REQ-1:0] core_bus_req,
  output logic             core_req_ack,
  output logic             grant_n,
  output logic             grant_oe,
  output logic             addr_oe,
  output logic             data_oe,
  output logic             sel_oe,
  output logic             strobe_oe,
  output logic             core_stall
);
  localparam int N_LINES = 4;

  own_t               state;
  logic               susp_seen;
  logic [N_LINES-1:0] line_oe;

  // named events for the checker
  logic ev_float;
  logic ev_grant;
  logic ev_own;

  hbus_seq u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_req_n       (host_req_n),
    .core_xfer_active (core_xfer_active),
    .state            (state)
  );

  hbus_susp u_susp (
    .clk       (clk),
    .rst_n     (rst_n),
    .suspend_n (suspend_n),
    .susp_seen (susp_seen)
  );

  hbus_drive #(.N_LINES(N_LINES)) u_drive (
    .state     (state),
    .susp_seen (susp_seen),
    .line_oe   (line_oe),
    .grant_n   (grant_n),
    .grant_oe  (grant_oe)
  );

  assign addr_oe   = line_oe[0];
  assign data_oe   = line_oe[1];
  assign sel_oe    = line_oe[2];
  assign strobe_oe = line_oe[3];

  assign ev_float = (state == HAND_OFF);
  assign ev_grant = (state == HOST_HAS);
  assign ev_own   = (state == OWN_CORE);

  assign core_stall   = fn_stall(core_xfer_req, suspend_n, susp_seen, state);
  assign core_req_ack = ev_own && host_req_n && (|core_bus_req);
endmodule

// File: rtl/hbus_arbiter_chk.sv
module hbus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic host_req_n,
  input logic suspend_n,
  input logic core_xfer_req,
  input logic core_xfer_active,
  input logic core_req_ack,
  input logic grant_n,
  input logic grant_oe,
  input logic addr_oe,
  input logic data_oe,
  input logic sel_oe,
  input logic strobe_oe,
  input logic core_stall,
  input logic ev_float,
  input logic ev_grant,
  input logic ev_own
);
  a_r2_float_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own && !host_req_n && !core_xfer_active |=>
      !grant_oe && !addr_oe && !data_oe && !sel_oe && !strobe_oe);

  a_r3_grant_after_float: assert property (@(posedge clk) disable iff (!rst_n)
    ev_float && !host_req_n |=> grant_oe && !grant_n);

  a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant && !host_req_n |=> grant_oe && !grant_n && !addr_oe);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_grant && host_req_n |=> grant_oe && grant_n);

  a_r6_hold_for_access: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own && core_xfer_active |=> grant_oe && grant_n);

  a_r7_host_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req_n |-> !core_req_ack);

  a_r8_suspend_float: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend_n |=> !addr_oe && !data_oe && !sel_oe && !strobe_oe);

  a_r9_stall_live: assert property (@(posedge clk) disable iff (!rst_n)
    core_xfer_req && !suspend_n |-> core_stall);

  a_r10_float_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ev_float && host_req_n |=> grant_oe && grant_n);
endmodule

bind hbus_arbiter hbus_arbiter_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .host_req_n       (host_req_n),
  .suspend_n        (suspend_n),
  .core_xfer_req    (core_xfer_req),
  .core_xfer_active (core_xfer_active),
  .core_req_ack     (core_req_ack),
  .grant_n          (grant_n),
  .grant_oe         (grant_oe),
  .addr_oe          (addr_oe),
  .data_oe          (data_oe),
  .sel_oe           (sel_oe),
  .strobe_oe        (strobe_oe),
  .core_stall       (core_stall),
  .ev_float         (ev_float),
  .ev_grant         (ev_grant),
  .ev_own           (ev_own)
);

// File: tb/test_hbus_arbiter.sv
module test_hbus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req_n = 1'b1;
  logic       suspend_n = 1'b1;
  logic       core_xfer_req = 1'b0;
  logic       core_xfer_active = 1'b0;
  logic [1:0] core_bus_req = 2'b00;
  logic       core_req_ack, grant_n, grant_oe, addr_oe, data_oe, sel_oe, strobe_oe, core_stall;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  hbus_arbiter #(.N_REQ(2)) i_hbus_arbiter (
    .clk(clk), .rst_n(rst_n), .host_req_n(host_req_n), .suspend_n(suspend_n),
    .core_xfer_req(core_xfer_req), .core_xfer_active(core_xfer_active),
    .core_bus_req(core_bus_req), .core_req_ack(core_req_ack), .grant_n(grant_n),
    .grant_oe(grant_oe), .addr_oe(addr_oe), .data_oe(data_oe), .sel_oe(sel_oe),
    .strobe_oe(strobe_oe), .core_stall(core_stall)
  );

  // [10]host_req_n [9]suspend_n [8]xfer_req [7]xfer_active [6:5]bus_req
  // [4]grant_oe [3]grant_n [2]bus oe [1]stall [0]ack
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b1_1_0_0_01_1_1_1_0_1,  // R7 ack when host idle
    11'b0_1_0_1_01_1_1_1_0_0,  // R6 access in flight keeps bus; R7 ack 0
    11'b0_1_0_0_01_0_1_0_0_0,  // R2 float
    11'b0_1_1_0_10_1_0_0_1_0,  // R3 grant low; R9 stall under host
    11'b0_1_0_0_00_1_0_0_0_0,  // R4 hold
    11'b1_1_0_0_11_1_1_1_0_1,  // R5 release
    11'b1_0_1_0_00_1_1_0_1_0,  // R8 suspend floats; R9
    11'b1_0_1_0_00_1_1_0_1_0,  // R8
    11'b1_1_1_0_00_1_1_1_0_0,  // R8 restore; R9 stall drops
    11'b0_1_0_0_00_0_1_0_0_0,  // R2
    11'b1_1_0_0_01_1_1_1_0_1,  // R10 abort
    11'b1_0_1_0_00_1_1_0_1_0,  // R8
    11'b0_0_0_0_00_0_1_0_0_0,  // R2 during suspend
    11'b0_1_0_0_00_1_0_0_0_0,  // R3
    11'b1_1_0_0_00_1_1_1_0_0   // R5
  };
  localparam int TAG [NV] = '{7, 6, 2, 3, 4, 5, 8, 8, 8, 2, 10, 8, 2, 3, 5};

  task automatic chk(input int tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input int tag, input logic goe, input logic gn, input logic boe,
                         input logic st, input logic ak);
    chk(tag, "grant_oe", grant_oe, goe);
    chk(tag, "grant_n", grant_n, gn);
    chk(tag, "addr_oe", addr_oe, boe);
    chk(tag, "data_oe", data_oe, boe);
    chk(tag, "sel_oe", sel_oe, boe);
    chk(tag, "strobe_oe", strobe_oe, boe);
    chk(tag, "core_stall", core_stall, st);
    chk(tag, "core_req_ack", core_req_ack, ak);
  endtask

  initial begin
    #1600000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all(1, 1, 1, 1, 0, 0);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(1, 1, 1, 1, 0, 0);  // R1 after reset

    for (int i = 0; i < NV; i++) begin
      host_req_n       = VEC[i][10];
      suspend_n        = VEC[i][9];
      core_xfer_req    = VEC[i][8];
      core_xfer_active = VEC[i][7];
      core_bus_req     = VEC[i][6:5];
      @(negedge clk);
      chk_all(TAG[i], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R9: stall follows suspend_n in the same cycle, before any edge
    @(posedge clk);
    #1;
    core_xfer_req = 1'b1;
    suspend_n = 1'b0;
    #1;
    chk(9, "core_stall live", core_stall, 1'b1);
    chk(8, "addr_oe before edge", addr_oe, 1'b1);
    suspend_n = 1'b1;
    core_xfer_req = 1'b0;
    @(negedge clk);

    // R6: long access defers hand-over, then one float cycle, then grant
    core_xfer_active = 1'b1;
    host_req_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(6, "grant_oe during access", grant_oe, 1'b1);
      chk(6, "addr_oe during access", addr_oe, 1'b1);
    end
    core_xfer_active = 1'b0;
    @(negedge clk);
    chk(2, "grant_oe float", grant_oe, 1'b0);
    @(negedge clk);
    chk(3, "grant_n", grant_n, 1'b0);

    // R1: reset in the middle of a grant restores processor ownership
    rst_n = 1'b0;
    #1;
    chk_all(1, 1, 1, 1, 0, 0);
    host_req_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(1, 1, 1, 1, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule